// File: doc/BRIEF.md
# Counter-Indexed Multiplexer UART Transmitter

This block turns one byte into a UART frame on a single serial line. It keeps no shift register. A small slot counter walks through a fixed table of line levels, and a multiplexer picks the level for the current slot. The table holds mark lead-in slots, the start bit, the eight data bits from a character register that is captured once, an optional parity slot, and the stop bit. The counter only moves on a baud-rate enable, so the block runs on the system clock. Baud generation and any queueing of characters are left to the logic around it.

A client waits until `readyOut` is high and then raises `sendIn`. The rising edge loads the byte and the mode, and the block leaves the idle state. The data and mode inputs may change from the next clock on. After the stop slot the counter returns to zero and `readyOut` rises again.

Top module: `uart_mux_tx`

## Requirements
- R1: While reset is held and right after it is released, `readyOut` is 1 and `txOut` is 1.
- R2: When the slot counter is 0 and `sendIn` goes from 0 to 1 (a rising edge sampled on `clk`), the byte on `dataIn` and the mode on `modeSel` are captured and the counter becomes 1. `readyOut` is 0 after that clock edge. Later changes on `dataIn` or `modeSel` do not alter the frame. This holds even when `baudTick` is high in the same cycle.
- R3: While the counter is non-zero, it advances by one on each clock where `baudTick` is 1 and holds its value on every other clock.
- R4: The line level for each counter value is as follows. Slots 0, 1 and 2 give 1. Slot 3 gives the start bit 0. Slots 4 to 11 give data bits 0 to 7, least significant first. Slot 13 gives the stop bit 1. A baud tick at slot 13 returns the counter to 0 (it never holds 14), so `readyOut` rises 13 ticks after the load.
- R5: Slot 12 carries the parity level set by the captured mode. Mode 100 gives 0. Mode 101 gives 1. Mode 110 gives the XOR of the eight data bits (even parity). Mode 111 gives the inverse of that XOR (odd parity).
- R6: With captured mode bit 2 equal to 0 (modes 0XX, no parity), slot 12 outputs 1.
- R7: `txOut` is a register. After each clock edge it shows the table level for the counter value held before that edge.
- R8: A rising edge of `sendIn` while the counter is non-zero is ignored. If `sendIn` is still held high when the frame ends, no new frame starts until `sendIn` falls and rises again.
- R9: `readyOut` is 1 exactly when the counter is 0, and `txOut` is 1 whenever `readyOut` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-clock enable, once per bit period |
| sendIn | input | 1 | Send request; its rising edge starts a frame |
| dataIn | input | DATA_W | Byte to send, captured on the start edge |
| modeSel | input | 3 | Parity mode, captured on the start edge |
| txOut | output | 1 | Serial line, idles high |
| readyOut | output | 1 | High while the transmitter is idle |

## Verification
The slot counter is the only control state, so a wrong counter value shows on `txOut` one clock later, as a misplaced start bit, a data bit from the wrong slot, or a parity or stop level in the wrong place. A counter that wraps early or late changes when `readyOut` rises, and the bench sees this at the first tick after slot 13. A bad character or mode register shows up only at the slot that reads it, so every data slot and the parity slot are compared against a model of the frame, and each slot is sampled again over idle clocks between ticks.

// File: rtl/uart_mux_tx_pkg.sv
package uart_mux_tx_pkg;
  // width of the parity mode select
  localparam int MODE_W = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadChar;  // capture byte and mode
    logic baudStep;  // counter moves this cycle
  } txStrobe_t;
endpackage

// File: rtl/uart_mux_tx_ctrl.sv
module uart_mux_tx_ctrl
  import uart_mux_tx_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int LAST_SLOT = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             sendIn,
  output txStrobe_t        strb,
  output logic [CNT_W-1:0] slotCnt,
  output logic             readyOut
);
  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(LAST_SLOT);
  localparam logic [CNT_W-1:0] FIRST_V = CNT_W'(1);

  logic sendPrev;
  logic sendRise;
  logic idle;

  assign idle     = (slotCnt == '0);
  assign sendRise = sendIn & ~sendPrev;
  assign readyOut = idle;

  always_comb begin
    strb          = '0;
    strb.loadChar = idle & sendRise;
    strb.baudStep = ~idle & baudTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt  <= '0;
      sendPrev <= 1'b0;
    end else begin
      sendPrev <= sendIn;
      if (strb.loadChar) begin
        slotCnt <= FIRST_V;
      end else if (strb.baudStep) begin
        slotCnt <= (slotCnt == LAST_V) ? '0 : slotCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_mux_tx_dp.sv
module uart_mux_tx_dp
  import uart_mux_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 4,
  parameter int START_SLOT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [CNT_W-1:0]  slotCnt,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [MODE_W-1:0] modeSel,
  output logic              txOut
);
  localparam int FIRST_DATA = START_SLOT + 1;
  localparam int PAR_SLOT   = FIRST_DATA + DATA_W;
  localparam int NUM_SLOTS  = 2 ** CNT_W;

  logic [DATA_W-1:0] charReg;
  logic [MODE_W-1:0] modeReg;
  logic              parityLvl;
  logic [NUM_SLOTS-1:0] slotLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      charReg <= '0;
      modeReg <= '0;
    end else if (strb.loadChar) begin
      charReg <= dataIn;
      modeReg <= modeSel;
    end
  end

  // bit2: parity slot used, bit1: computed parity, bit0: fixed level / odd sense
  always_comb begin
    if (!modeReg[2])     parityLvl = 1'b1;
    else if (modeReg[1]) parityLvl = (^charReg) ^ modeReg[0];
    else                 parityLvl = modeReg[0];
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g == START_SLOT) begin : g_start
      assign slotLvl[g] = 1'b0;
    end else if (g >= FIRST_DATA && g < PAR_SLOT) begin : g_data
      assign slotLvl[g] = charReg[g-FIRST_DATA];
    end else if (g == PAR_SLOT) begin : g_par
      assign slotLvl[g] = parityLvl;
    end else begin : g_mark
      assign slotLvl[g] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) txOut <= 1'b1;
    else       txOut <= slotLvl[slotCnt];
  end
endmodule

// File: rtl/uart_mux_tx.sv
module uart_mux_tx
  import uart_mux_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 4,
  parameter int PRE_MARKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              sendIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [2:0]        modeSel,
  output logic              txOut,
  output logic              readyOut
);
  localparam int START_SLOT = PRE_MARKS + 1;
  localparam int LAST_SLOT  = START_SLOT + DATA_W + 2;

  txStrobe_t        strb;
  logic [CNT_W-1:0] slotCnt;

  uart_mux_tx_ctrl #(.CNT_W(CNT_W), .LAST_SLOT(LAST_SLOT)) ctrl_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .sendIn(sendIn),
    .strb(strb), .slotCnt(slotCnt), .readyOut(readyOut)
  );

  uart_mux_tx_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .START_SLOT(START_SLOT)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .slotCnt(slotCnt),
    .dataIn(dataIn), .modeSel(modeSel), .txOut(txOut)
  );
endmodule

// File: rtl/uart_mux_tx_chk.sv
module uart_mux_tx_chk #(
  parameter int CNT_W      = 4,
  parameter int START_SLOT = 3,
  parameter int LAST_SLOT  = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             baudTick,
  input logic             sendIn,
  input logic             txOut,
  input logic             readyOut,
  input logic [CNT_W-1:0] slotCnt
);
  localparam logic [CNT_W-1:0] START_V = CNT_W'(START_SLOT);
  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(LAST_SLOT);

  a_r9_idle_mark: assert property (@(posedge clk) disable iff (!rstN)
    readyOut |-> txOut);

  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    (readyOut && sendIn && !$past(sendIn)) |=> (!readyOut && slotCnt == CNT_W'(1)));

  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && !baudTick) |=> $stable(slotCnt));

  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && baudTick && slotCnt != LAST_V) |=> !readyOut);

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (baudTick && slotCnt == LAST_V) |=> readyOut);

  a_r4_range: assert property (@(posedge clk) disable iff (!rstN)
    slotCnt <= LAST_V);

  a_r7_start_low: assert property (@(posedge clk) disable iff (!rstN)
    (slotCnt == START_V) |=> !txOut);
endmodule

bind uart_mux_tx uart_mux_tx_chk #(
  .CNT_W(CNT_W), .START_SLOT(START_SLOT), .LAST_SLOT(LAST_SLOT)
) chk_i (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .sendIn(sendIn),
  .txOut(txOut), .readyOut(readyOut), .slotCnt(slotCnt)
);

// File: tb/uart_mux_tx_tb_top.sv
module uart_mux_tx_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       sendIn = 1'b0;
  logic [7:0] dataIn = '0;
  logic [2:0] modeSel = '0;
  logic       txOut;
  logic       readyOut;

  int vecCnt = 0;
  int errCnt = 0;
  int cycCnt = 0;
  bit doneFlag = 0;

  always #10 clk = ~clk;

  uart_mux_tx dut_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .sendIn(sendIn),
    .dataIn(dataIn), .modeSel(modeSel), .txOut(txOut), .readyOut(readyOut)
  );

  function automatic logic expLevel(int s, logic [7:0] d, logic [2:0] m);
    if (s == 3) return 1'b0;                      // R4 start
    if (s >= 4 && s <= 11) return d[s-4];         // R4 data LSB first
    if (s == 12) begin
      if (!m[2]) return 1'b1;                     // R6
      if (m[1]) return (^d) ^ m[0];               // R5 even/odd
      return m[0];                                // R5 fixed
    end
    return 1'b1;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(logic tick);
    baudTick = tick;
    @(posedge clk);
    #1;
    baudTick = 1'b0;
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  endtask

  // sends one frame; pokeSlot>0 pulses sendIn at that slot; holdSend keeps it high at end
  task automatic sendFrame(logic [7:0] d, logic [2:0] m, logic loadTick,
                           int pokeSlot, bit holdSend);
    sendIn = 1'b1; dataIn = d; modeSel = m;
    cyc(loadTick);
    chk("R2 ready low after load", readyOut, 1'b0);
    sendIn = 1'b0;
    dataIn = ~d; modeSel = m ^ 3'b111;           // R2 inputs free to change
    for (int s = 1; s <= 13; s++) begin
      cyc(1'b0);
      chk($sformatf("R4 slot %0d level", s), txOut, expLevel(s, d, m));
      for (int k = 0; k < int'($urandom_range(0, 2)); k++) begin
        if (s == pokeSlot) sendIn = ~sendIn;      // R8 edges while busy
        cyc(1'b0);
        chk($sformatf("R3 slot %0d held", s), txOut, expLevel(s, d, m));
        chk("R3 still busy", readyOut, 1'b0);
      end
      if (s == pokeSlot) begin sendIn = 1'b0; cyc(1'b0); sendIn = 1'b1; end
      if (s == 13 && holdSend) sendIn = 1'b1;
      cyc(1'b1);
      if (s < 13) chk("R3 busy after tick", readyOut, 1'b0);
    end
    chk("R4 ready after wrap", readyOut, 1'b1);
    chk("R9 line high at wrap", txOut, 1'b1);
    if (pokeSlot == 0 && !holdSend) sendIn = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycCnt++;
      if (cycCnt > 150000) begin
        errCnt++;
        $display("FAIL watchdog: actual timeout expected completion");
        finishRun();
      end
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rstN = 1'b0;
    sendIn = 1'b1;
    repeat (3) cyc(1'b1);
    chk("R1 ready in reset", readyOut, 1'b1);
    chk("R1 line in reset", txOut, 1'b1);
    sendIn = 1'b0;
    cyc(1'b0);
    rstN = 1'b1;
    cyc(1'b1);
    chk("R1 ready after reset", readyOut, 1'b1);
    chk("R1 line after reset", txOut, 1'b1);
    // R3 ticks while idle do nothing
    repeat (3) begin
      cyc(1'b1);
      chk("R9 idle ready", readyOut, 1'b1);
      chk("R9 idle line", txOut, 1'b1);
    end

    // directed: each parity mode (R5, R6), load with tick (R2)
    sendFrame(8'hA5, 3'b000, 1'b1, 0, 0);
    sendFrame(8'h01, 3'b011, 1'b0, 0, 0);
    sendFrame(8'h00, 3'b100, 1'b0, 0, 0);
    sendFrame(8'h00, 3'b101, 1'b0, 0, 0);
    sendFrame(8'h07, 3'b110, 1'b1, 0, 0);
    sendFrame(8'h07, 3'b111, 1'b0, 0, 0);
    sendFrame(8'hFF, 3'b110, 1'b0, 0, 0);
    sendFrame(8'h80, 3'b111, 1'b0, 0, 0);

    // R8: edges during a frame and level held at the end
    sendFrame(8'h3C, 3'b110, 1'b0, 6, 1);
    repeat (4) begin
      cyc(1'b1);
      chk("R8 held send no restart", readyOut, 1'b1);
      chk("R8 line idle", txOut, 1'b1);
    end
    sendIn = 1'b0;
    cyc(1'b0);

    // random frames
    for (int n = 0; n < 40; n++) begin
      sendFrame(8'($urandom), 3'($urandom), 1'($urandom), 0, 0);
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
        cyc(1'($urandom));
        chk("R9 gap idle", readyOut, 1'b1);
        chk("R9 gap line", txOut, 1'b1);
      end
    end
    finishRun();
  end
endmodule